// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a synchronous parallel display panel from a single interface clock. A horizontal counter walks through each line of a programmed total length. A vertical counter walks through the lines of a frame. From these two counters the block derives the line and frame sync pulses, a data-enable strobe for the active window, a per-component strobe, and the current active pixel column and row.

A pixel may occupy several interface clocks, one component per clock. The block marks the first component of every pixel and advances the column once per pixel. Both sync widths are programmed in half-clock units. An odd width stretches the pulse by the first half of one further clock, using a flop on the falling clock edge.

Timing values arrive through a simple write port into shadow registers. They are copied into the working set only at a frame boundary, so a frame is always produced with one consistent set of timing values. A configuration whose leading blanking plus active span does not fit inside the total, on either axis, raises an error output and keeps data enable low.

Top module: `disp_tmg_top`

## Requirements
- R1: While reset is held, the horizontal, vertical and frame-clock counters are zero and the default timing is in force: hSync and vSync are high, dataEn is low and cfgErr is low.
- R2: The horizontal count runs 0 to lineLen-1 (lineLen written at address 0, in interface clocks including both blanking intervals), and the vertical count advances once per line, running 0 to frameLen-1 (address 4, in lines), so a new frame, and a new vSync pulse, starts every lineLen*frameLen clocks.
- R3: hSync width is written at address 1 in half clocks as W. hSync is high for horizontal counts below W/2 (integer part). When bit 0 of W is set, it is also high during the first half of the clock at count W/2.
- R4: vSync width is written at address 5 in half clocks as W, counted in interface clocks from frame start (frame-clock count f). vSync is high while f < W/2, and also during the first half of the clock at f = W/2 when bit 0 of W is set.
- R5: dataEn is high exactly when the horizontal count lies in [hLead, hLead+hAct) and the vertical count lies in [vLead, vLead+vAct). Here hLead, hAct, vLead and vAct are written at addresses 2, 3, 6 and 7.
- R6: With P interface clocks per pixel (address 8, where 0 counts as 1), compStrobe equals dataEn. Numbering the active clocks of a line k = 0,1,..., pixStart is high when k mod P is 0, and pixCol equals k/P.
- R7: pixRow equals the vertical count minus vLead while dataEn is high; pixCol and pixRow are zero while dataEn is low.
- R8: A write lands in a shadow register and takes effect at the first frame start after the write edge. The frame in progress keeps its old timing.
- R9: Writes to addresses 9 to 15 change nothing.
- R10: cfgErr is high, and dataEn, compStrobe and pixStart are low, whenever hLead+hAct >= lineLen or vLead+vAct >= frameLen in the working set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the timing registers |
| wrAddr | input | 4 | Timing register address |
| wrData | input | TW+1 | Write data |
| hSync | output | 1 | Line sync pulse |
| vSync | output | 1 | Frame sync pulse |
| dataEn | output | 1 | Active-window data enable |
| compStrobe | output | 1 | One pulse per component clock in the active window |
| pixStart | output | 1 | First component of a pixel |
| pixCol | output | TW | Active pixel column |
| pixRow | output | TW | Active pixel row |
| cfgErr | output | 1 | Working configuration does not fit |

## Verification
The hardest situation to reach is a timing write that lands in the middle of a frame, because the old values must hold until the exact clock at which both counters wrap. The wrap must then switch line length, sync widths and the pixel grouping together. The stimulus writes a whole new configuration partway through a frame and keeps running across the boundary. On every clock, a bench model that holds separate shadow and working copies predicts each output, and the sync outputs are sampled in both halves of the clock. That way the half-clock stretch is checked on each side of the change, including a width of a single half clock.

// File: rtl/disp_tmg_pkg.sv
package disp_tmg_pkg;

  // Strobes handed from the control side to the counting datapath.
  typedef struct packed {
    logic cfgBad;
    logic hHalf;
    logic vHalf;
  } tmgStrobe_t;

  // Timing register addresses.
  typedef enum logic [3:0] {
    REG_LINE  = 4'd0,
    REG_HSW   = 4'd1,
    REG_HLEAD = 4'd2,
    REG_HACT  = 4'd3,
    REG_FRAME = 4'd4,
    REG_VSW   = 4'd5,
    REG_VLEAD = 4'd6,
    REG_VACT  = 4'd7,
    REG_CPP   = 4'd8
  } tmgReg_e;

endpackage

// File: rtl/disp_tmg_ctrl.sv
module disp_tmg_ctrl
  import disp_tmg_pkg::*;
#(
  parameter int TW        = 12,
  parameter int PW        = 4,
  parameter int DEF_LINE  = 16,
  parameter int DEF_HSW   = 3,
  parameter int DEF_HLEAD = 3,
  parameter int DEF_HACT  = 8,
  parameter int DEF_FRAME = 6,
  parameter int DEF_VSW   = 40,
  parameter int DEF_VLEAD = 1,
  parameter int DEF_VACT  = 3,
  parameter int DEF_CPP   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [TW:0]   wrData,
  input  logic          frameEnd,
  output logic [TW-1:0] lineLen,
  output logic [TW-1:0] hLead,
  output logic [TW-1:0] hAct,
  output logic [TW-1:0] frameLen,
  output logic [TW-1:0] vLead,
  output logic [TW-1:0] vAct,
  output logic [PW-1:0] cpp,
  output logic [TW-1:0] hsIntNxt,
  output logic [TW-1:0] vsIntNxt,
  output tmgStrobe_t    strobe
);

  localparam int SW = TW + 1;

  // shadow copies
  logic [TW-1:0] lineS, hLeadS, hActS, frameS, vLeadS, vActS;
  logic [SW-1:0] hswS, vswS;
  logic [PW-1:0] cppS;
  // working copies
  logic [TW-1:0] lineW, hLeadW, hActW, frameW, vLeadW, vActW;
  logic [SW-1:0] hswW, vswW;
  logic [PW-1:0] cppW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineS  <= TW'(DEF_LINE);
      hswS   <= SW'(DEF_HSW);
      hLeadS <= TW'(DEF_HLEAD);
      hActS  <= TW'(DEF_HACT);
      frameS <= TW'(DEF_FRAME);
      vswS   <= SW'(DEF_VSW);
      vLeadS <= TW'(DEF_VLEAD);
      vActS  <= TW'(DEF_VACT);
      cppS   <= PW'(DEF_CPP);
    end else if (wrEn) begin
      case (wrAddr)
        REG_LINE:  lineS  <= wrData[TW-1:0];
        REG_HSW:   hswS   <= wrData;
        REG_HLEAD: hLeadS <= wrData[TW-1:0];
        REG_HACT:  hActS  <= wrData[TW-1:0];
        REG_FRAME: frameS <= wrData[TW-1:0];
        REG_VSW:   vswS   <= wrData;
        REG_VLEAD: vLeadS <= wrData[TW-1:0];
        REG_VACT:  vActS  <= wrData[TW-1:0];
        REG_CPP:   cppS   <= wrData[PW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineW  <= TW'(DEF_LINE);
      hswW   <= SW'(DEF_HSW);
      hLeadW <= TW'(DEF_HLEAD);
      hActW  <= TW'(DEF_HACT);
      frameW <= TW'(DEF_FRAME);
      vswW   <= SW'(DEF_VSW);
      vLeadW <= TW'(DEF_VLEAD);
      vActW  <= TW'(DEF_VACT);
      cppW   <= PW'(DEF_CPP);
    end else if (frameEnd) begin
      lineW  <= lineS;
      hswW   <= hswS;
      hLeadW <= hLeadS;
      hActW  <= hActS;
      frameW <= frameS;
      vswW   <= vswS;
      vLeadW <= vLeadS;
      vActW  <= vActS;
      cppW   <= cppS;
    end
  end

  logic hBad, vBad;
  always_comb begin
    hBad = ({1'b0, hLeadW} + {1'b0, hActW}) >= {1'b0, lineW};
    vBad = ({1'b0, vLeadW} + {1'b0, vActW}) >= {1'b0, frameW};
  end

  assign lineLen  = lineW;
  assign hLead    = hLeadW;
  assign hAct     = hActW;
  assign frameLen = frameW;
  assign vLead    = vLeadW;
  assign vAct     = vActW;
  assign cpp      = (cppW == '0) ? PW'(1) : cppW;
  // integer part of the sync widths as they will be in the coming clock
  assign hsIntNxt = frameEnd ? hswS[SW-1:1] : hswW[SW-1:1];
  assign vsIntNxt = frameEnd ? vswS[SW-1:1] : vswW[SW-1:1];

  assign strobe.cfgBad = hBad | vBad;
  assign strobe.hHalf  = hswW[0];
  assign strobe.vHalf  = vswW[0];

endmodule

// File: rtl/disp_sync_pulse.sv
module disp_sync_pulse #(
  parameter int CNTW     = 12,
  parameter int WIDW     = 12,
  parameter bit HALF_RES = 1'b1,
  parameter bit RST_ON   = 1'b1,
  parameter bit RST_LAST = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CNTW-1:0] cntNxt,
  input  logic [WIDW-1:0] widIntNxt,
  input  logic            halfBit,
  output logic            syncOut
);

  localparam int MW = (CNTW > WIDW) ? CNTW : WIDW;

  logic [MW-1:0] cntX, widX;
  logic onQ, lastQ;

  assign cntX = MW'(cntNxt);
  assign widX = MW'(widIntNxt);

  // onQ: whole clocks of the pulse; lastQ: the clock right after them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onQ   <= RST_ON;
      lastQ <= RST_LAST;
    end else begin
      onQ   <= cntX < widX;
      lastQ <= cntX == widX;
    end
  end

  generate
    if (HALF_RES) begin : g_half
      logic lastN;
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) lastN <= 1'b0;
        else       lastN <= lastQ;
      end
      // lastQ & ~lastN is high only in the first half of the extra clock
      assign syncOut = onQ | (halfBit & lastQ & ~lastN);
    end else begin : g_whole
      assign syncOut = onQ;
    end
  endgenerate

endmodule

// File: rtl/disp_tmg_dp.sv
module disp_tmg_dp
  import disp_tmg_pkg::*;
#(
  parameter int TW        = 12,
  parameter int PW        = 4,
  parameter int FCW       = 20,
  parameter bit HALF_RES  = 1'b1,
  parameter bit H_RST_ON  = 1'b1,
  parameter bit H_RST_LST = 1'b0,
  parameter bit V_RST_ON  = 1'b1,
  parameter bit V_RST_LST = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] lineLen,
  input  logic [TW-1:0] hLead,
  input  logic [TW-1:0] hAct,
  input  logic [TW-1:0] frameLen,
  input  logic [TW-1:0] vLead,
  input  logic [TW-1:0] vAct,
  input  logic [PW-1:0] cpp,
  input  logic [TW-1:0] hsIntNxt,
  input  logic [TW-1:0] vsIntNxt,
  input  tmgStrobe_t    strobe,
  output logic          frameEnd,
  output logic          hSync,
  output logic          vSync,
  output logic          dataEn,
  output logic          compStrobe,
  output logic          pixStart,
  output logic [TW-1:0] pixCol,
  output logic [TW-1:0] pixRow
);

  logic [TW-1:0]  hCnt, vCnt, hNext, vNext, colCnt;
  logic [FCW-1:0] fCnt, fNext;
  logic [PW-1:0]  compCnt;
  logic hWrap, vWrap, hWin, vWin, de;

  always_comb begin
    hWrap    = ({1'b0, hCnt} + 1'b1) >= {1'b0, lineLen};
    vWrap    = ({1'b0, vCnt} + 1'b1) >= {1'b0, frameLen};
    frameEnd = hWrap & vWrap;
    hNext    = hWrap ? '0 : hCnt + 1'b1;
    if (!hWrap)     vNext = vCnt;
    else if (vWrap) vNext = '0;
    else            vNext = vCnt + 1'b1;
    if (frameEnd)       fNext = '0;
    else if (&fCnt)     fNext = fCnt;
    else                fNext = fCnt + 1'b1;
    hWin = (hCnt >= hLead) && ({1'b0, hCnt} < ({1'b0, hLead} + {1'b0, hAct}));
    vWin = (vCnt >= vLead) && ({1'b0, vCnt} < ({1'b0, vLead} + {1'b0, vAct}));
    de   = hWin & vWin & ~strobe.cfgBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
      fCnt <= '0;
    end else begin
      hCnt <= hNext;
      vCnt <= vNext;
      fCnt <= fNext;
    end
  end

  // component and column counters, restarted at every line start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      compCnt <= '0;
      colCnt  <= '0;
    end else if (hWrap) begin
      compCnt <= '0;
      colCnt  <= '0;
    end else if (hWin) begin
      if (({1'b0, compCnt} + 1'b1) >= {1'b0, cpp}) begin
        compCnt <= '0;
        colCnt  <= colCnt + 1'b1;
      end else begin
        compCnt <= compCnt + 1'b1;
      end
    end
  end

  disp_sync_pulse #(
    .CNTW(TW), .WIDW(TW), .HALF_RES(HALF_RES),
    .RST_ON(H_RST_ON), .RST_LAST(H_RST_LST)
  ) u_hsync (
    .clk(clk), .rstN(rstN), .cntNxt(hNext), .widIntNxt(hsIntNxt),
    .halfBit(strobe.hHalf), .syncOut(hSync)
  );

  disp_sync_pulse #(
    .CNTW(FCW), .WIDW(TW), .HALF_RES(HALF_RES),
    .RST_ON(V_RST_ON), .RST_LAST(V_RST_LST)
  ) u_vsync (
    .clk(clk), .rstN(rstN), .cntNxt(fNext), .widIntNxt(vsIntNxt),
    .halfBit(strobe.vHalf), .syncOut(vSync)
  );

  assign dataEn     = de;
  assign compStrobe = de;
  assign pixStart   = de & (compCnt == '0);
  assign pixCol     = de ? colCnt : '0;
  assign pixRow     = de ? (vCnt - vLead) : '0;

endmodule

// File: rtl/disp_tmg_top.sv
module disp_tmg_top
  import disp_tmg_pkg::*;
#(
  parameter int TW        = 12,
  parameter int PW        = 4,
  parameter int FCW       = 20,
  parameter bit HALF_RES  = 1'b1,
  parameter int DEF_LINE  = 16,
  parameter int DEF_HSW   = 3,
  parameter int DEF_HLEAD = 3,
  parameter int DEF_HACT  = 8,
  parameter int DEF_FRAME = 6,
  parameter int DEF_VSW   = 40,
  parameter int DEF_VLEAD = 1,
  parameter int DEF_VACT  = 3,
  parameter int DEF_CPP   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [TW:0]   wrData,
  output logic          hSync,
  output logic          vSync,
  output logic          dataEn,
  output logic          compStrobe,
  output logic          pixStart,
  output logic [TW-1:0] pixCol,
  output logic [TW-1:0] pixRow,
  output logic          cfgErr
);

  localparam bit H_RST_ON  = (DEF_HSW / 2) > 0;
  localparam bit H_RST_LST = (DEF_HSW / 2) == 0;
  localparam bit V_RST_ON  = (DEF_VSW / 2) > 0;
  localparam bit V_RST_LST = (DEF_VSW / 2) == 0;

  logic [TW-1:0] lineLen, hLead, hAct, frameLen, vLead, vAct, hsIntNxt, vsIntNxt;
  logic [PW-1:0] cpp;
  logic          frameEnd;
  tmgStrobe_t    strobe;

  disp_tmg_ctrl #(
    .TW(TW), .PW(PW),
    .DEF_LINE(DEF_LINE), .DEF_HSW(DEF_HSW), .DEF_HLEAD(DEF_HLEAD),
    .DEF_HACT(DEF_HACT), .DEF_FRAME(DEF_FRAME), .DEF_VSW(DEF_VSW),
    .DEF_VLEAD(DEF_VLEAD), .DEF_VACT(DEF_VACT), .DEF_CPP(DEF_CPP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .lineLen(lineLen), .hLead(hLead), .hAct(hAct),
    .frameLen(frameLen), .vLead(vLead), .vAct(vAct), .cpp(cpp),
    .hsIntNxt(hsIntNxt), .vsIntNxt(vsIntNxt), .strobe(strobe)
  );

  disp_tmg_dp #(
    .TW(TW), .PW(PW), .FCW(FCW), .HALF_RES(HALF_RES),
    .H_RST_ON(H_RST_ON), .H_RST_LST(H_RST_LST),
    .V_RST_ON(V_RST_ON), .V_RST_LST(V_RST_LST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineLen(lineLen), .hLead(hLead), .hAct(hAct),
    .frameLen(frameLen), .vLead(vLead), .vAct(vAct), .cpp(cpp),
    .hsIntNxt(hsIntNxt), .vsIntNxt(vsIntNxt), .strobe(strobe),
    .frameEnd(frameEnd), .hSync(hSync), .vSync(vSync), .dataEn(dataEn),
    .compStrobe(compStrobe), .pixStart(pixStart), .pixCol(pixCol),
    .pixRow(pixRow)
  );

  assign cfgErr = strobe.cfgBad;

endmodule

// File: rtl/disp_tmg_checker.sv
module disp_tmg_checker #(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          dataEn,
  input logic          compStrobe,
  input logic          pixStart,
  input logic [TW-1:0] pixCol,
  input logic [TW-1:0] pixRow,
  input logic          cfgErr
);

  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  // R10: a bad configuration never lets data through
  p_err_blocks_de_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!dataEn && !compStrobe && !pixStart));

  // R6: pixel starts only inside the active window
  p_start_in_de_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixStart |-> dataEn);

  // R7: coordinates are zero outside the active window
  p_zero_outside_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataEn |-> (pixCol == '0 && pixRow == '0));

  // R6: a later component of a pixel always follows an active clock
  p_comp_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && dataEn && !pixStart) |-> $past(dataEn));

  // R6: a new pixel after an active clock moves one column on
  p_col_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && pixStart && $past(dataEn)) |-> (pixCol == $past(pixCol) + 1'b1));

endmodule

bind disp_tmg_top disp_tmg_checker #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .dataEn(dataEn), .compStrobe(compStrobe),
  .pixStart(pixStart), .pixCol(pixCol), .pixRow(pixRow), .cfgErr(cfgErr)
);

// File: tb/sim_disp_tmg_top.sv
module sim_disp_tmg_top;

  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [3:0]    wrAddr = '0;
  logic [TW:0]   wrData = '0;
  logic          hSync, vSync, dataEn, compStrobe, pixStart, cfgErr;
  logic [TW-1:0] pixCol, pixRow;

  always #10 clk = ~clk;   // 50 MHz

  disp_tmg_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .compStrobe(compStrobe),
    .pixStart(pixStart), .pixCol(pixCol), .pixRow(pixRow), .cfgErr(cfgErr)
  );

  int checks = 0;
  int failures = 0;
  string tag = "";

  // bench model: 0 line,1 hsw,2 hlead,3 hact,4 frame,5 vsw,6 vlead,7 vact,8 cpp
  int shadowR [9] = '{16, 3, 3, 8, 6, 40, 1, 3, 2};
  int workR   [9] = '{16, 3, 3, 8, 6, 40, 1, 3, 2};
  int h = 0, v = 0, f = 0;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit expErr();
    return (workR[2] + workR[3] >= workR[0]) || (workR[6] + workR[7] >= workR[4]);
  endfunction

  function automatic bit expDe();
    bit hw, vw;
    hw = (h >= workR[2]) && (h < workR[2] + workR[3]);
    vw = (v >= workR[6]) && (v < workR[6] + workR[7]);
    return hw && vw && !expErr();
  endfunction

  function automatic bit expSync(input int cnt, input int w, input bit firstHalf);
    if (cnt < w / 2) return 1'b1;
    return firstHalf && (w % 2 == 1) && (cnt == w / 2);
  endfunction

  task automatic checkFirst();
    int p, k;
    bit de;
    de = expDe();
    p  = (workR[8] == 0) ? 1 : workR[8];
    k  = h - workR[2];
    chk(int'(hSync), int'(expSync(h, workR[1], 1'b1)), "R2 R3 hSync first half");
    chk(int'(vSync), int'(expSync(f, workR[5], 1'b1)), "R2 R4 vSync first half");
    chk(int'(dataEn), int'(de), "R5 dataEn");
    chk(int'(cfgErr), int'(expErr()), "R10 cfgErr");
    chk(int'(compStrobe), int'(de), "R6 compStrobe");
    chk(int'(pixStart), int'(de && (k % p == 0)), "R6 pixStart");
    chk(int'(pixCol), de ? k / p : 0, "R6 R7 pixCol");
    chk(int'(pixRow), de ? v - workR[6] : 0, "R7 pixRow");
  endtask

  task automatic checkSecond();
    chk(int'(hSync), int'(expSync(h, workR[1], 1'b0)), "R3 hSync second half");
    chk(int'(vSync), int'(expSync(f, workR[5], 1'b0)), "R4 vSync second half");
  endtask

  // called about 2 ns before a rising edge
  task automatic step(input bit we, input int a, input int d);
    bit hw, fe;
    wrEn = we; wrAddr = 4'(a); wrData = (TW+1)'(d);
    @(posedge clk);
    hw = (h + 1 >= workR[0]);
    fe = hw && (v + 1 >= workR[4]);
    if (hw) begin
      h = 0;
      v = (v + 1 >= workR[4]) ? 0 : v + 1;
    end else h++;
    f = fe ? 0 : f + 1;
    if (fe) workR = shadowR;
    if (we && a < 9) shadowR[a] = d;
    #5 checkFirst();
    #10 checkSecond();
    #3 wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  task automatic runToFrameEnd();
    // advance until the model sits at the last clock of a frame
    while (!((h + 1 >= workR[0]) && (v + 1 >= workR[4]))) step(1'b0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #5;
    tag = "R1";
    chk(int'(hSync), 1, "R1 reset hSync");
    chk(int'(vSync), 1, "R1 reset vSync");
    chk(int'(dataEn), 0, "R1 reset dataEn");
    chk(int'(cfgErr), 0, "R1 reset cfgErr");
    chk(int'(pixCol), 0, "R1 reset pixCol");
    #13 rstN = 1'b1;

    tag = "R2 defaults";
    idle(2 * 16 * 6 + 5);

    // new configuration written mid-frame; old one must hold until frame start
    tag = "R8 reload";
    step(1'b1, 0, 10);
    step(1'b1, 1, 4);
    step(1'b1, 2, 2);
    step(1'b1, 3, 6);
    step(1'b1, 4, 5);
    step(1'b1, 5, 15);
    step(1'b1, 6, 1);
    step(1'b1, 7, 2);
    step(1'b1, 8, 3);
    chk(workR[0], 16, "R8 model still on old line length");
    idle(2 * 10 * 5 + 60);

    // writes to unused addresses
    tag = "R9 unused";
    runToFrameEnd();
    step(1'b1, 9, 1);
    step(1'b1, 12, 0);
    step(1'b1, 15, 8191);
    idle(2 * 10 * 5 + 3);

    // one component per pixel (0 means 1) and a half-clock-only sync
    tag = "R6 R3 cpp0";
    step(1'b1, 8, 0);
    step(1'b1, 1, 1);
    step(1'b1, 5, 1);
    idle(2 * 10 * 5 + 4);

    // horizontal misfit
    tag = "R10 horiz";
    step(1'b1, 2, 5);
    step(1'b1, 3, 5);
    step(1'b1, 8, 2);
    idle(2 * 10 * 5 + 4);

    // vertical misfit with the horizontal axis repaired
    tag = "R10 vert";
    step(1'b1, 2, 1);
    step(1'b1, 3, 7);
    step(1'b1, 6, 2);
    step(1'b1, 7, 3);
    step(1'b1, 5, 9);
    idle(2 * 10 * 5 + 4);

    // back to a fitting frame with three components per pixel
    tag = "R5 recover";
    step(1'b1, 7, 2);
    step(1'b1, 8, 3);
    step(1'b1, 1, 5);
    idle(2 * 10 * 5 + 4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule